// File: doc/BRIEF.md
# Work-Steal Backoff Controller

This block decides when a processing element goes looking for work in other elements, and which element it asks. While the local task queue reports empty, the controller counts down a wait period and then sends exactly one steal request that names a victim element. It holds off until that request is answered. A successful answer carries a task, which the controller hands straight to the local queue. It also shrinks the wait period back to a single cycle. A failed answer doubles the wait period, up to a ceiling. This throttles steal traffic when there is little parallel work, and lets the element react at once when work appears again.

Victims come from a linear feedback shift register that advances every clock. Its seed is mixed with the element's own ID, so elements that leave reset together draw different sequences. Each cycle the low bits of the register form a candidate victim. A candidate is kept only if it names an element that exists and is not this element. The request always uses the most recent legal candidate, so an illegal draw never delays a request.

The finite state machine has four states. `ST_IDLE` loads the wait timer and moves to `ST_WAIT` when the queue is empty. `ST_WAIT` returns to `ST_IDLE` if the queue fills (abandon). Otherwise it moves to `ST_REQ` when the timer expires. `ST_REQ` always moves to `ST_RESP` after one cycle. `ST_RESP` moves to `ST_IDLE` when a response arrives, on success and on failure alike.

Top module: `steal_backoff_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after its release, `req_valid` and `push_valid` are 0. The wait period restarts at 1.
- R2: No request is issued while `queue_empty` is 0.
- R3: With wait period P, `req_valid` is high in the (P+1)-th cycle after the first cycle spent idle with `queue_empty` high. The first request after reset therefore comes 2 cycles after that cycle.
- R4: A failed response (`resp_valid`=1, `resp_success`=0) doubles the wait period used for the next request.
- R5: The wait period never exceeds `MAX_WAIT`. A failure at the ceiling leaves it at `MAX_WAIT`.
- R6: A successful response (`resp_valid`=1, `resp_success`=1) drives `push_valid`=1 and `push_task`=`resp_task` in the same cycle, and resets the wait period to 1.
- R7: Every request names a victim below `NUM_PE` that differs from `my_id`.
- R8: `req_valid` is high for exactly one cycle per request. No further request is issued until a response has been received.
- R9: If `queue_empty` drops while the controller is waiting, no request is sent. The period reached so far is kept for the next attempt.
- R10: A response that arrives while no request is outstanding is ignored. `push_valid` stays 0 and the wait period does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| my_id | input | ID_W | ID of this processing element; also seeds victim selection |
| queue_empty | input | 1 | Local task queue holds no task |
| resp_valid | input | 1 | A steal response is present this cycle |
| resp_success | input | 1 | 1: response carries a task; 0: steal failed |
| resp_task | input | TASK_W | Task carried by a successful response |
| req_valid | output | 1 | One-cycle steal request pulse |
| req_victim | output | ID_W | Element addressed by the request |
| push_valid | output | 1 | Stolen task is handed to the local queue this cycle |
| push_task | output | TASK_W | Stolen task |

## Verification
The bench builds the controller with `NUM_PE`=5 and `MAX_WAIT`=8. With these values the ceiling is reached after three failures, so the saturation step sits within a short directed run. Five elements do not fill a 3-bit code, so the LFSR regularly draws IDs that do not exist, and the victim filter is exercised against both out-of-range codes and the element's own ID. The element ID is set to 2, 0 and 4 in turn, which covers a middle ID and both ends, including the wrap of the initial victim choice.

// File: rtl/steal_pkg.sv
package steal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_REQ  = 2'd2,
        ST_RESP = 2'd3
    } steal_state_e;

    function automatic int unsigned id_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/steal_victim_lfsr.sv
module steal_victim_lfsr #(
    parameter int unsigned NUM_PE = 8,
    parameter int unsigned LFSR_W = 8,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A,
    localparam int unsigned ID_W = steal_pkg::id_width(NUM_PE)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] my_id,
    output logic [ID_W-1:0] victim_o
);
    localparam logic [ID_W:0]   PE_COUNT = NUM_PE[ID_W:0];
    localparam logic [ID_W-1:0] LAST_ID  = ID_W'(NUM_PE - 1);

    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] seed_mix;
    logic [LFSR_W-1:0] seed_w;
    logic [ID_W-1:0]   cand;
    logic              cand_ok;
    logic [ID_W-1:0]   victim_q;
    logic [ID_W-1:0]   victim_init;

    always_comb begin
        seed_mix = LFSR_SEED ^ {{(LFSR_W-ID_W){1'b0}}, my_id};
        seed_w   = (seed_mix == '0) ? LFSR_W'(1) : seed_mix;
        cand     = lfsr_q[ID_W-1:0];
        cand_ok  = ({1'b0, cand} < PE_COUNT) && (cand != my_id);
        victim_init = (my_id == LAST_ID) ? '0 : my_id + ID_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= seed_w;
        end else begin
            lfsr_q <= {lfsr_q[LFSR_W-2:0], ^(lfsr_q & LFSR_TAPS)};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_q <= victim_init;
        end else if (cand_ok) begin
            victim_q <= cand;
        end
    end

    assign victim_o = victim_q;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0); // R7
    AST_VICTIM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, victim_q} < PE_COUNT) && (victim_q != my_id)); // R7

endmodule

// File: rtl/steal_backoff_period.sv
module steal_backoff_period #(
    parameter int unsigned MAX_WAIT = 128,
    localparam int unsigned PW = $clog2(MAX_WAIT) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fail_i,
    input  logic          succ_i,
    output logic [PW-1:0] period_o
);
    localparam logic [PW-1:0] CAP  = MAX_WAIT[PW-1:0];
    localparam logic [PW-1:0] HALF = CAP >> 1;
    localparam logic [PW-1:0] ONE  = PW'(1);

    logic [PW-1:0] period_q;
    logic [PW-1:0] period_d;

    always_comb begin
        period_d = period_q;
        if (succ_i) begin
            period_d = ONE;
        end else if (fail_i) begin
            period_d = (period_q >= HALF) ? CAP : (period_q << 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= ONE;
        end else begin
            period_q <= period_d;
        end
    end

    assign period_o = period_q;

    AST_PERIOD_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (period_q != '0) && (period_q <= CAP)); // R5
    AST_PERIOD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        succ_i |=> (period_q == ONE)); // R6
    AST_PERIOD_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_i && !succ_i) |=> (period_q == CAP) || (period_q == ($past(period_q) << 1))); // R4
    AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fail_i && !succ_i) |=> $stable(period_q)); // R9

endmodule

// File: rtl/steal_wait_timer.sv
module steal_wait_timer #(
    parameter int unsigned MAX_WAIT = 128,
    localparam int unsigned PW = $clog2(MAX_WAIT) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [PW-1:0] value_i,
    input  logic          dec_i,
    output logic          expired_o
);
    localparam logic [PW-1:0] ONE = PW'(1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ONE;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (dec_i && (cnt_q > ONE)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expired_o = (cnt_q <= ONE);

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i && !expired_o) |=> (cnt_q == $past(cnt_q) - ONE)); // R3

endmodule

// File: rtl/steal_backoff_ctrl.sv
module steal_backoff_ctrl #(
    parameter int unsigned NUM_PE   = 8,
    parameter int unsigned MAX_WAIT = 128,
    parameter int unsigned TASK_W   = 32,
    parameter int unsigned LFSR_W   = 8,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A,
    localparam int unsigned ID_W = steal_pkg::id_width(NUM_PE),
    localparam int unsigned PW   = $clog2(MAX_WAIT) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   my_id,
    input  logic              queue_empty,
    input  logic              resp_valid,
    input  logic              resp_success,
    input  logic [TASK_W-1:0] resp_task,
    output logic              req_valid,
    output logic [ID_W-1:0]   req_victim,
    output logic              push_valid,
    output logic [TASK_W-1:0] push_task
);
    import steal_pkg::*;

    steal_state_e  state_q, state_d;
    logic [PW-1:0] period;
    logic          expired;
    logic          tmr_load, tmr_dec;
    logic          got_fail, got_succ;
    logic [ID_W-1:0] victim;

    steal_victim_lfsr #(
        .NUM_PE   (NUM_PE),
        .LFSR_W   (LFSR_W),
        .LFSR_TAPS(LFSR_TAPS),
        .LFSR_SEED(LFSR_SEED)
    ) victim_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .my_id   (my_id),
        .victim_o(victim)
    );

    steal_backoff_period #(
        .MAX_WAIT(MAX_WAIT)
    ) period_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fail_i  (got_fail),
        .succ_i  (got_succ),
        .period_o(period)
    );

    steal_wait_timer #(
        .MAX_WAIT(MAX_WAIT)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .value_i  (period),
        .dec_i    (tmr_dec),
        .expired_o(expired)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (queue_empty) state_d = ST_WAIT;
            ST_WAIT: begin
                if (!queue_empty) begin
                    state_d = ST_IDLE;
                end else if (expired) begin
                    state_d = ST_REQ;
                end
            end
            ST_REQ:  state_d = ST_RESP;
            ST_RESP: if (resp_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        req_valid  = 1'b0;
        push_valid = 1'b0;
        tmr_load   = 1'b0;
        tmr_dec    = 1'b0;
        got_fail   = 1'b0;
        got_succ   = 1'b0;
        unique case (state_q)
            ST_IDLE: tmr_load = queue_empty;
            ST_WAIT: tmr_dec  = queue_empty;
            ST_REQ:  req_valid = 1'b1;
            ST_RESP: begin
                push_valid = resp_valid && resp_success;
                got_succ   = resp_valid && resp_success;
                got_fail   = resp_valid && !resp_success;
            end
            default: ;
        endcase
        req_victim = victim;
        push_task  = resp_task;
    end

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid); // R8
    AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!queue_empty && state_q != ST_REQ) |=> !req_valid); // R2
    AST_AWAIT_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESP && !resp_valid) |=> (state_q == ST_RESP)); // R8
    AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RESP) |-> !push_valid); // R10

endmodule

// File: tb/steal_backoff_ctrl_tb_top.sv
module steal_backoff_ctrl_tb_top;

    localparam int unsigned NUM_PE   = 5;
    localparam int unsigned MAX_WAIT = 8;
    localparam int unsigned TASK_W   = 16;
    localparam int unsigned ID_W     = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ID_W-1:0]   my_id = '0;
    logic              queue_empty = 1'b0;
    logic              resp_valid = 1'b0;
    logic              resp_success = 1'b0;
    logic [TASK_W-1:0] resp_task = '0;
    logic              req_valid;
    logic [ID_W-1:0]   req_victim;
    logic              push_valid;
    logic [TASK_W-1:0] push_task;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    steal_backoff_ctrl #(
        .NUM_PE  (NUM_PE),
        .MAX_WAIT(MAX_WAIT),
        .TASK_W  (TASK_W)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .my_id       (my_id),
        .queue_empty (queue_empty),
        .resp_valid  (resp_valid),
        .resp_success(resp_success),
        .resp_task   (resp_task),
        .req_valid   (req_valid),
        .req_victim  (req_victim),
        .push_valid  (push_valid),
        .push_task   (push_task)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    // R1: reset state
    task automatic t_reset(input int id);
        @(negedge clk);
        my_id = ID_W'(id);
        rst_n = 1'b0;
        queue_empty = 1'b0;
        resp_valid = 1'b0;
        resp_success = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(!req_valid && !push_valid, "R1 outputs during reset", req_valid, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check(!req_valid && !push_valid, "R1 outputs after reset", req_valid, 0);
    endtask

    // R3: count cycles from an idle+empty cycle to the request; R7 on victim
    task automatic t_wait_req(input int period, input string tag);
        int n = 0;
        queue_empty = 1'b1;
        do begin
            @(negedge clk);
            n++;
        end while (!req_valid && n < 100);
        check(n == period + 1, tag, n, period + 1);
        check((int'(req_victim) < NUM_PE) && (req_victim != my_id),
              "R7 victim legal", int'(req_victim), int'(my_id));
    endtask

    // R6 / R8: answer the outstanding request
    task automatic t_answer(input bit ok, input logic [TASK_W-1:0] task_v);
        @(negedge clk);
        check(!req_valid, "R8 request lasts one cycle", req_valid, 0);
        resp_valid = 1'b1;
        resp_success = ok;
        resp_task = task_v;
        #1;
        check(push_valid == ok, "R6 push on response", push_valid, ok);
        if (ok) check(push_task == task_v, "R6 pushed task", push_task, task_v);
        @(negedge clk);
        resp_valid = 1'b0;
        resp_success = 1'b0;
    endtask

    task automatic sc_backoff();
        t_reset(2);
        t_wait_req(1, "R3 first request after one-cycle wait");
        t_answer(1'b0, '0);
        t_wait_req(2, "R4 period doubled to 2");
        t_answer(1'b0, '0);
        t_wait_req(4, "R4 period doubled to 4");
        t_answer(1'b0, '0);
        t_wait_req(8, "R5 period reaches cap");
        t_answer(1'b0, '0);
        t_wait_req(8, "R5 period held at cap");
        t_answer(1'b1, 16'hBEEF);
        t_wait_req(1, "R6 period reset after success");
    endtask

    task automatic sc_outstanding();
        repeat (20) begin
            @(negedge clk);
            check(!req_valid, "R8 no request while outstanding", req_valid, 0);
        end
        t_answer(1'b0, '0);
        t_wait_req(2, "R4 doubled after late failure");
        t_answer(1'b0, '0);
    endtask

    task automatic sc_abandon();
        queue_empty = 1'b1;
        repeat (2) @(negedge clk);
        queue_empty = 1'b0;
        repeat (20) begin
            @(negedge clk);
            check(!req_valid, "R2 R9 no request after queue fills", req_valid, 0);
        end
    endtask

    task automatic sc_stray();
        resp_valid = 1'b1;
        resp_success = 1'b1;
        resp_task = 16'h1234;
        repeat (4) begin
            #1;
            check(!push_valid, "R10 stray success not pushed", push_valid, 0);
            @(negedge clk);
        end
        resp_success = 1'b0;
        repeat (4) @(negedge clk);
        resp_valid = 1'b0;
        check(!req_valid, "R10 no request from stray", req_valid, 0);
        t_wait_req(4, "R9 R10 period kept at 4");
        t_answer(1'b1, 16'h0F0F);
    endtask

    task automatic sc_victims(input int id);
        t_reset(id);
        for (int i = 0; i < 8; i++) begin
            t_wait_req(1, "R3 R7 repeated steal");
            t_answer(1'b1, TASK_W'(i));
        end
    endtask

    initial begin
        sc_backoff();
        sc_outstanding();
        sc_abandon();
        sc_stray();
        sc_victims(0);
        sc_victims(4);
        finish_run();
    end

endmodule